// File: doc/BRIEF.md
# Super-Pixel Zero-Suppressing Packet Builder

This block serves a 4x4 group of 16 pixels that share one readout path. Each cycle of the bunch-crossing clock (25 ns per timestamp step), any pixel may signal a hit and supply a 4-bit time-over-threshold (ToT) value. The block keeps only the pixels that fired. It groups them into a cluster tagged with the current timestamp. It then sends the cluster as a packet of variable length over an 8-bit column bus, one byte per clock, with a valid/ready handshake.

A packet starts with a four-byte header: the super-pixel address, the timestamp, and the 16-bit hit map. A payload of ToT nibbles follows, one nibble for each fired pixel, packed two per byte. A single-pixel packet is therefore 5 bytes and a full packet is 12 bytes. A pending stage sits between the pixels and the serialiser. It holds the next cluster while the current packet drains, and it merges further hits that carry the same timestamp. The address input is a static strap that sets the position of the group on the column.

Top module: `spx_packet_builder`

## Requirements
- R1: While reset is asserted, and until the first hit is taken, `bus_vld` is low.
- R2: Header layout by byte position: byte 0 is `sp_addr`, byte 1 is the cluster timestamp, byte 2 is hit-map bits 15..8 and byte 3 is hit-map bits 7..0. Map bit i is set when pixel i fired.
- R3: After the header come the ToT values of the fired pixels, in ascending pixel index. The first value goes in bits 7:4 of a byte and the second in bits 3:0. A trailing unused nibble is zero. With n fired pixels the packet is 4 + ceil(n/2) bytes long.
- R4: `bus_sop` marks exactly the first byte of a packet and `bus_eop` marks exactly the last. After an accepted end byte, the next valid byte is a start byte.
- R5: Hits are clustered in the pending stage. All hits sampled in one cycle form one cluster. While a cluster waits in that stage, hits whose timestamp equals its timestamp are merged into it. The cluster keeps its first timestamp, and a pixel that hits twice keeps its first ToT.
- R6: Hits that arrive while a packet is being sent go into the pending cluster and leave as the next packet. While the cluster waits, hits with a different timestamp are discarded.
- R7: A byte moves only on a clock edge where `bus_vld` and `bus_rdy` are both high. While `bus_vld` is high and `bus_rdy` is low, `bus_data`, `bus_vld`, `bus_sop` and `bus_eop` stay unchanged.
- R8: A cycle in which no pixel hits creates no packet.
- R9: A hit sampled at edge k, with the serialiser idle, gives a start byte that is valid after edge k+1. If a cluster is pending when an end byte is accepted, the next start byte is valid in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sp_addr | input | 8 | Static super-pixel address strap |
| bx_ts | input | 8 | Bunch-crossing timestamp counter |
| hit | input | 16 | Per-pixel hit strobes, bit i = pixel i |
| tot | input | 64 | Per-pixel ToT, pixel i in bits 4i+3..4i |
| bus_rdy | input | 1 | Column bus ready |
| bus_data | output | 8 | Column bus byte |
| bus_vld | output | 1 | Byte valid |
| bus_sop | output | 1 | First byte of a packet |
| bus_eop | output | 1 | Last byte of a packet |

## Verification
A hit sampled at edge k reaches the pending stage at that edge. It appears as a start byte after edge k+1, so the bench checks at the falling edge after edge k that `bus_vld` is still low, and at the next falling edge that the start byte is present. During a packet every output is sampled at the falling edge. Inputs change only at falling edges, so `bus_rdy` is set there and a byte counts as moved only if valid and ready were both high at that sample. A stalled byte is compared one falling edge later. The back-to-back case expects the next start byte one falling edge after the end byte was taken.

// File: rtl/spx_packet_builder.sv
module spx_packet_builder #(
  parameter int NPIX  = 16,
  parameter int TOT_W = 4,
  parameter int BUS_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [BUS_W-1:0]        sp_addr,
  input  logic [BUS_W-1:0]        bx_ts,
  input  logic [NPIX-1:0]         hit,
  input  logic [NPIX*TOT_W-1:0]   tot,
  input  logic                    bus_rdy,
  output logic [BUS_W-1:0]        bus_data,
  output logic                    bus_vld,
  output logic                    bus_sop,
  output logic                    bus_eop
);
  localparam int NIB_PB  = BUS_W / TOT_W;
  localparam int MAP_B   = NPIX / BUS_W;
  localparam int HDR_N   = 2 + MAP_B;
  localparam int PAY_W   = NPIX * TOT_W;
  localparam int PKT_MAX = HDR_N + PAY_W / BUS_W;
  localparam int IDX_W   = $clog2(PKT_MAX);

  logic              pend_vld;
  logic [NPIX-1:0]   pend_map;
  logic [PAY_W-1:0]  pend_tot;
  logic [BUS_W-1:0]  pend_ts;

  logic              snd_vld;
  logic [NPIX-1:0]   snd_map;
  logic [PAY_W-1:0]  snd_pay;
  logic [BUS_W-1:0]  snd_ts;
  logic [IDX_W-1:0]  snd_idx;
  logic [IDX_W-1:0]  snd_last;

  logic [PAY_W-1:0]  pack;
  logic [IDX_W-1:0]  last_c;
  logic [BUS_W-1:0]  byte_c;

  wire xfer = snd_vld & bus_rdy;
  wire done = xfer & (snd_idx == snd_last);
  wire move = pend_vld & (~snd_vld | done);

  always_comb begin
    int unsigned k;
    pack = '0;
    k = 0;
    for (int i = 0; i < NPIX; i++) begin
      if (pend_map[i]) begin
        pack[PAY_W-1-k*TOT_W -: TOT_W] = pend_tot[i*TOT_W +: TOT_W];
        k++;
      end
    end
    last_c = IDX_W'(HDR_N - 1 + (int'($countones(pend_map)) + NIB_PB - 1) / NIB_PB);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
      pend_map <= '0;
      pend_tot <= '0;
      pend_ts  <= '0;
    end else if (!pend_vld || move) begin
      pend_vld <= |hit;
      pend_map <= hit;
      pend_tot <= tot;
      pend_ts  <= bx_ts;
    end else if ((|hit) && bx_ts == pend_ts) begin
      pend_map <= pend_map | hit;
      for (int i = 0; i < NPIX; i++)
        if (hit[i] && !pend_map[i])
          pend_tot[i*TOT_W +: TOT_W] <= tot[i*TOT_W +: TOT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snd_vld  <= 1'b0;
      snd_map  <= '0;
      snd_pay  <= '0;
      snd_ts   <= '0;
      snd_idx  <= '0;
      snd_last <= '0;
    end else if (move) begin
      snd_vld  <= 1'b1;
      snd_map  <= pend_map;
      snd_pay  <= pack;
      snd_ts   <= pend_ts;
      snd_idx  <= '0;
      snd_last <= last_c;
    end else if (done) begin
      snd_vld <= 1'b0;
    end else if (xfer) begin
      snd_idx <= snd_idx + 1'b1;
    end
  end

  always_comb begin
    int ix;
    ix = int'(snd_idx);
    if (ix == 0)          byte_c = sp_addr;
    else if (ix == 1)     byte_c = snd_ts;
    else if (ix < HDR_N)  byte_c = snd_map[NPIX-1-(ix-2)*BUS_W -: BUS_W];
    else                  byte_c = snd_pay[PAY_W-1-(ix-HDR_N)*BUS_W -: BUS_W];
  end

  assign bus_data = byte_c;
  assign bus_vld  = snd_vld;
  assign bus_sop  = snd_vld & (snd_idx == '0);
  assign bus_eop  = snd_vld & (snd_idx == snd_last);

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_vld && !bus_rdy) |=> (bus_vld && $stable(bus_data) && $stable(bus_sop) && $stable(bus_eop))); // R7

  AST_START_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_vld && bus_rdy && bus_eop) |=> (!bus_vld || bus_sop)); // R4

  AST_NO_EMPTY_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_vld && bus_sop) |-> (snd_map != '0)); // R8

  AST_PEND_TS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vld && $past(pend_vld && !move)) |-> $stable(pend_ts)); // R5

  AST_PEND_MAP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vld && $past(pend_vld && !move)) |-> ((pend_map & $past(pend_map)) == $past(pend_map))); // R5
endmodule

// File: tb/spx_packet_builder_tb.sv
`timescale 1ns/1ps
module spx_packet_builder_tb_top;
  localparam logic [7:0] ADDR = 8'h5A;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bx_ts;
  logic [15:0] hit;
  logic [63:0] tot;
  logic        bus_rdy;
  logic [7:0]  bus_data;
  logic        bus_vld, bus_sop, bus_eop;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_b [12];
  int         exp_n;
  logic [7:0] got_b [12];
  int         got_n;

  always #2 clk = ~clk;

  spx_packet_builder dut_i (
    .clk(clk), .rst_n(rst_n), .sp_addr(ADDR), .bx_ts(bx_ts), .hit(hit), .tot(tot),
    .bus_rdy(bus_rdy), .bus_data(bus_data), .bus_vld(bus_vld),
    .bus_sop(bus_sop), .bus_eop(bus_eop)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  function automatic logic [63:0] mk_tot(input int seed);
    logic [63:0] v;
    for (int p = 0; p < 16; p++) v[p*4 +: 4] = 4'((p * 5 + seed) & 15);
    return v;
  endfunction

  task automatic build_exp(input logic [7:0] t, input logic [15:0] m, input logic [63:0] tv);
    int k;
    exp_b[0] = ADDR;
    exp_b[1] = t;
    exp_b[2] = m[15:8];
    exp_b[3] = m[7:0];
    for (int j = 4; j < 12; j++) exp_b[j] = 8'h00;
    k = 0;
    for (int p = 0; p < 16; p++) begin
      if (m[p]) begin
        if (k % 2 == 0) exp_b[4 + k/2][7:4] = tv[p*4 +: 4];
        else            exp_b[4 + k/2][3:0] = tv[p*4 +: 4];
        k++;
      end
    end
    exp_n = 4 + (k + 1) / 2;
  endtask

  task automatic send_hits(input logic [15:0] m, input logic [63:0] tv, input logic [7:0] t);
    @(negedge clk);
    hit = m; tot = tv; bx_ts = t;
    @(negedge clk);
    hit = '0;
    chk(!bus_vld, "R9 no byte one cycle after hit", bus_vld, 0);
  endtask

  task automatic collect(input int mode, input bit immediate);
    bit done, prev_stall;
    logic [7:0] pd;
    logic ps, pe;
    done = 0; prev_stall = 0; got_n = 0; pd = '0; ps = 0; pe = 0;
    for (int c = 0; c < 200 && !done; c++) begin
      @(negedge clk);
      if (c == 0 && immediate)
        chk(bus_vld && bus_sop, "R9 start byte due", {bus_vld, bus_sop}, 3);
      if (prev_stall)
        chk(bus_vld && bus_data == pd && bus_sop == ps && bus_eop == pe,
            "R7 held while stalled", bus_data, pd);
      bus_rdy = (mode == 0) ? 1'b1 : ((c + mode) % 3 != 0);
      prev_stall = bus_vld && !bus_rdy;
      pd = bus_data; ps = bus_sop; pe = bus_eop;
      if (bus_vld && bus_rdy) begin
        chk(bus_sop == (got_n == 0), "R4 start marker", bus_sop, got_n == 0);
        if (got_n < 12) got_b[got_n] = bus_data;
        got_n++;
        if (bus_eop) done = 1;
      end
    end
    chk(done, "R4 end marker seen", done, 1);
    chk(got_n == exp_n, "R3 packet length", got_n, exp_n);
    for (int j = 0; j < exp_n && j < got_n && j < 12; j++)
      chk(got_b[j] == exp_b[j], (j < 4) ? "R2 header byte" : "R3 payload byte", got_b[j], exp_b[j]);
  endtask

  task automatic idle_quiet(input string req);
    bit seen;
    seen = 0;
    bus_rdy = 1'b1;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (bus_vld) seen = 1;
    end
    chk(!seen, req, seen, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] m;
    logic [63:0] t1, t2, tu;
    rst_n = 1'b0; hit = '0; tot = '0; bx_ts = '0; bus_rdy = 1'b0;
    repeat (3) @(negedge clk);
    chk(!bus_vld, "R1 idle in reset", bus_vld, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_vld, "R1 idle after reset", bus_vld, 0);

    // R2 R3 R4 R7 R9: sweep over occupancy and pixel patterns
    for (int j = 0; j < 80; j++) begin
      if (j < 16)       m = 16'hFFFF >> (15 - j);
      else if (j == 16) m = 16'h8000;
      else begin
        m = 16'((j * 40503) ^ (j << 5));
        if (m == 0) m = 16'h0001;
      end
      send_hits(m, mk_tot(j), 8'(j * 7 + 3));
      build_exp(8'(j * 7 + 3), m, mk_tot(j));
      collect(j % 4, 1);
    end

    idle_quiet("R8 no packet without hits");

    // R5 R6: cluster latched and merged while a packet is stalled
    bus_rdy = 1'b0;
    send_hits(16'h0021, mk_tot(3), 8'h40);
    t1 = mk_tot(1);
    t2 = mk_tot(9);
    @(negedge clk); hit = 16'h00F0; tot = t1; bx_ts = 8'h41;
    @(negedge clk); hit = 16'h0318; tot = t2; bx_ts = 8'h41;
    @(negedge clk); hit = 16'hC000; tot = t1; bx_ts = 8'h42;
    @(negedge clk); hit = '0;
    chk(bus_vld && bus_sop && bus_data == ADDR, "R7 stalled start byte", bus_data, ADDR);
    build_exp(8'h40, 16'h0021, mk_tot(3));
    collect(0, 0);
    tu = t2;
    for (int p = 4; p < 8; p++) tu[p*4 +: 4] = t1[p*4 +: 4];
    build_exp(8'h41, 16'h03F8, tu);
    collect(0, 1);
    idle_quiet("R6 other-timestamp hits discarded");

    summary();
    $finish;
  end
endmodule